// File: doc/BRIEF.md
# Address-Space Tagged Translation Buffer

This block caches virtual-to-physical page translations for a processor core. Each cached entry carries a 6-bit address-space tag next to its virtual page number, so translations from several processes can stay resident at once. A lookup only matches entries whose tag equals the running context, unless the entry is marked as shared by all contexts. The all-ones tag value is reserved: the running context can never take it, so software invalidates an entry by rewriting its tag to that value.

Software maintains the entries through four word registers. One register picks an entry by index. Two registers, "upper" and "lower", then read or write that entry's tag half and translation half. A fourth register holds the running context. The translation port takes a virtual address, a write/read flag and a user/kernel flag. It returns hit, frame number and fault class through a one-deep registered result stage with valid/ready flow control. Entries are grouped four to a set, and the set is chosen by the low bits of the virtual page number. Software must therefore place each entry in the set that its page number selects.

Top module: `ctx_tlb`

## Requirements
- R1: After reset the running context reads 0, every entry reads with upper word 0x0000003F (page 0, reserved tag) and lower word 0, and no lookup hits.
- R2: Register address 0 holds the entry index (bits 5:0). Address 1 is the selected entry's upper word: page number in bits 31:13 and tag in bits 5:0, with other bits reading 0. Address 2 is its lower word: frame number in bits 31:13, shared flag bit 3, present flag bit 2, kernel-only flag bit 1 and writable flag bit 0. Address 3 is the running context (bits 5:0). A written value reads back on the next cycle.
- R3: A write of 63 to the context register is ignored and the old context remains. Any other value becomes the running context for lookups accepted from the next cycle on.
- R4: A lookup for page number V searches only the four entries whose index bits 5:2 equal V bits 3:0. An entry hits when its page number equals V and its tag equals the running context. The 13 page-offset bits are ignored.
- R5: An entry with the shared flag set hits regardless of the running context.
- R6: An entry tagged 63 never hits, even when its shared flag is set.
- R7: A hit on an entry whose present flag is clear reports fault code 1. This takes precedence over codes 2 and 3.
- R8: A user-mode lookup that hits a present kernel-only entry reports fault code 2. A kernel-mode lookup to the same entry reports 0.
- R9: A write lookup that hits a present, permitted entry with the writable flag clear reports fault code 3. A read lookup to the same entry reports 0.
- R10: A lookup accepted on a clock edge presents its result, with res_valid high, from that edge on. A miss reports hit 0, frame 0 and fault 0.
- R11: lk_ready equals !res_valid || res_ready. While res_valid is high and res_ready is low, the result holds unchanged and no new lookup is taken.
- R12: When several ways of a set hit, the way with the lowest index supplies frame and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 index, 1 upper, 2 lower, 3 context |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store access |
| lk_user | input | 1 | 1 for a user-mode access |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes result |
| res_hit | output | 1 | An entry matched |
| res_pfn | output | 19 | Physical frame number of the match |
| res_fault | output | 2 | 0 none, 1 not present, 2 privilege, 3 write-protect |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8 KB pages, 6-bit tags and 16 sets of 4 ways. This puts the reserved tag 63, the four-way lowest-index priority and misplaced entries that sit in a set other than their page number selects within reach. A table of lookups covers each fault class and the shared and reserved-tag cases under one context. Directed steps then cover reset contents, context switches, the ignored write of 63, invalidation by retagging, result timing and a stalled result.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_PRIV    = 2'd2,
    FLT_RDONLY  = 2'd3
  } tlb_fault_e;

  typedef enum logic [1:0] {
    RA_INDEX = 2'd0,
    RA_UPPER = 2'd1,
    RA_LOWER = 2'd2,
    RA_CTX   = 2'd3
  } tlb_reg_e;

  // flag bit positions inside the lower word
  localparam int FL_WRITABLE = 0;
  localparam int FL_KERNEL   = 1;
  localparam int FL_PRESENT  = 2;
  localparam int FL_SHARED   = 3;
  localparam int FL_W        = 4;

endpackage

// File: rtl/tlb_csr.sv
module tlb_csr
  import tlb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 6,
  parameter int CTX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [DW-1:0]    ent_upper,
  input  logic [DW-1:0]    ent_lower,
  output logic [IDX_W-1:0] sel_idx,
  output logic [CTX_W-1:0] cur_ctx,
  output logic             upper_we,
  output logic             lower_we,
  output logic [DW-1:0]    reg_rdata
);
  localparam logic [CTX_W-1:0] CTX_RSVD = '1;

  tlb_reg_e ra;
  assign ra = tlb_reg_e'(reg_addr);

  assign upper_we = reg_we && (ra == RA_UPPER);
  assign lower_we = reg_we && (ra == RA_LOWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx <= '0;
      cur_ctx <= '0;
    end else if (reg_we) begin
      if (ra == RA_INDEX) sel_idx <= reg_wdata[IDX_W-1:0];
      if ((ra == RA_CTX) && (reg_wdata[CTX_W-1:0] != CTX_RSVD))
        cur_ctx <= reg_wdata[CTX_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (ra)
      RA_INDEX: reg_rdata[IDX_W-1:0] = sel_idx;
      RA_UPPER: reg_rdata = ent_upper;
      RA_LOWER: reg_rdata = ent_lower;
      RA_CTX:   reg_rdata[CTX_W-1:0] = cur_ctx;
      default:  reg_rdata = '0;
    endcase
  end

  // R3: the reserved tag is never the running context
  a_r3_ctx_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ctx != CTX_RSVD);

  // R2: an index write is visible on the next cycle
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ra == RA_INDEX) |=> sel_idx == $past(reg_wdata[IDX_W-1:0]));

  // R3: a write of the reserved tag leaves the context alone
  a_r3_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ra == RA_CTX && reg_wdata[CTX_W-1:0] == CTX_RSVD) |=> $stable(cur_ctx));

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int CTX_W      = 6,
  parameter int GROUP_BITS = 4,
  parameter int WAY_BITS   = 2,
  localparam int VPN_W     = DW - PAGE_SHIFT,
  localparam int IDX_W     = GROUP_BITS + WAY_BITS,
  localparam int WAYS      = 1 << WAY_BITS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              upper_we,
  input  logic                              lower_we,
  input  logic [DW-1:0]                     wdata,
  output logic [DW-1:0]                     rd_upper,
  output logic [DW-1:0]                     rd_lower,
  input  logic [GROUP_BITS-1:0]             grp_sel,
  output logic [WAYS-1:0][VPN_W-1:0]        grp_vpn,
  output logic [WAYS-1:0][CTX_W-1:0]        grp_tag,
  output logic [WAYS-1:0][VPN_W-1:0]        grp_pfn,
  output logic [WAYS-1:0][FL_W-1:0]         grp_flg
);
  localparam int NUM_ENT = 1 << IDX_W;
  localparam logic [CTX_W-1:0] CTX_RSVD = '1;

  logic [VPN_W-1:0] vpn_q [NUM_ENT];
  logic [CTX_W-1:0] tag_q [NUM_ENT];
  logic [VPN_W-1:0] pfn_q [NUM_ENT];
  logic [FL_W-1:0]  flg_q [NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        vpn_q[i] <= '0;
        tag_q[i] <= CTX_RSVD;
        pfn_q[i] <= '0;
        flg_q[i] <= '0;
      end
    end else begin
      if (upper_we) begin
        vpn_q[wr_idx] <= wdata[DW-1:PAGE_SHIFT];
        tag_q[wr_idx] <= wdata[CTX_W-1:0];
      end
      if (lower_we) begin
        pfn_q[wr_idx] <= wdata[DW-1:PAGE_SHIFT];
        flg_q[wr_idx] <= wdata[FL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_upper = '0;
    rd_upper[DW-1:PAGE_SHIFT] = vpn_q[wr_idx];
    rd_upper[CTX_W-1:0]       = tag_q[wr_idx];
    rd_lower = '0;
    rd_lower[DW-1:PAGE_SHIFT] = pfn_q[wr_idx];
    rd_lower[FL_W-1:0]        = flg_q[wr_idx];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
    logic [IDX_W-1:0] ent;
    assign ent        = {grp_sel, WAY_BITS'(w)};
    assign grp_vpn[w] = vpn_q[ent];
    assign grp_tag[w] = tag_q[ent];
    assign grp_pfn[w] = pfn_q[ent];
    assign grp_flg[w] = flg_q[ent];
  end

  // R2: an upper-word write is readable from the selected entry next cycle
  a_r2_upper_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_we && !lower_we) |=> ($stable(wr_idx) -> rd_upper[CTX_W-1:0] == $past(wdata[CTX_W-1:0])));

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int VPN_W = 19,
  parameter int CTX_W = 6,
  parameter int WAYS  = 4
) (
  input  logic [VPN_W-1:0]             lk_vpn,
  input  logic [CTX_W-1:0]             cur_ctx,
  input  logic                         lk_write,
  input  logic                         lk_user,
  input  logic [WAYS-1:0][VPN_W-1:0]   grp_vpn,
  input  logic [WAYS-1:0][CTX_W-1:0]   grp_tag,
  input  logic [WAYS-1:0][VPN_W-1:0]   grp_pfn,
  input  logic [WAYS-1:0][FL_W-1:0]    grp_flg,
  output logic                         m_hit,
  output logic [VPN_W-1:0]             m_pfn,
  output tlb_fault_e                   m_fault
);
  localparam logic [CTX_W-1:0] CTX_RSVD = '1;

  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic tag_ok;
    assign tag_ok     = (grp_tag[w] == cur_ctx) || grp_flg[w][FL_SHARED];
    assign way_hit[w] = (grp_tag[w] != CTX_RSVD) && tag_ok && (grp_vpn[w] == lk_vpn);
  end

  logic [FL_W-1:0] sel_flg;

  always_comb begin
    m_hit   = 1'b0;
    m_pfn   = '0;
    sel_flg = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        m_hit   = 1'b1;
        m_pfn   = grp_pfn[w];
        sel_flg = grp_flg[w];
      end
    end
    m_fault = FLT_NONE;
    if (m_hit) begin
      if (!sel_flg[FL_PRESENT])                  m_fault = FLT_ABSENT;
      else if (lk_user && sel_flg[FL_KERNEL])    m_fault = FLT_PRIV;
      else if (lk_write && !sel_flg[FL_WRITABLE]) m_fault = FLT_RDONLY;
    end
  end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int CTX_W      = 6,
  parameter int GROUP_BITS = 4,
  parameter int WAY_BITS   = 2,
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT,
  localparam int IDX_W     = GROUP_BITS + WAY_BITS,
  localparam int WAYS      = 1 << WAY_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [VPN_W-1:0]  res_pfn,
  output logic [1:0]        res_fault
);
  logic [IDX_W-1:0]  sel_idx;
  logic [CTX_W-1:0]  cur_ctx;
  logic              upper_we, lower_we;
  logic [ADDR_W-1:0] ent_upper, ent_lower;

  tlb_csr #(.DW(ADDR_W), .IDX_W(IDX_W), .CTX_W(CTX_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ent_upper(ent_upper), .ent_lower(ent_lower),
    .sel_idx(sel_idx), .cur_ctx(cur_ctx), .upper_we(upper_we),
    .lower_we(lower_we), .reg_rdata(reg_rdata)
  );

  logic [VPN_W-1:0]                 lk_vpn;
  logic [WAYS-1:0][VPN_W-1:0]       grp_vpn, grp_pfn;
  logic [WAYS-1:0][CTX_W-1:0]       grp_tag;
  logic [WAYS-1:0][FL_W-1:0]        grp_flg;

  assign lk_vpn = lk_vaddr[ADDR_W-1:PAGE_SHIFT];

  tlb_array #(.DW(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .CTX_W(CTX_W),
              .GROUP_BITS(GROUP_BITS), .WAY_BITS(WAY_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_idx(sel_idx), .upper_we(upper_we),
    .lower_we(lower_we), .wdata(reg_wdata), .rd_upper(ent_upper),
    .rd_lower(ent_lower), .grp_sel(lk_vpn[GROUP_BITS-1:0]),
    .grp_vpn(grp_vpn), .grp_tag(grp_tag), .grp_pfn(grp_pfn), .grp_flg(grp_flg)
  );

  logic             m_hit;
  logic [VPN_W-1:0] m_pfn;
  tlb_fault_e       m_fault;

  tlb_match #(.VPN_W(VPN_W), .CTX_W(CTX_W), .WAYS(WAYS)) u_match (
    .lk_vpn(lk_vpn), .cur_ctx(cur_ctx), .lk_write(lk_write), .lk_user(lk_user),
    .grp_vpn(grp_vpn), .grp_tag(grp_tag), .grp_pfn(grp_pfn), .grp_flg(grp_flg),
    .m_hit(m_hit), .m_pfn(m_pfn), .m_fault(m_fault)
  );

  tlb_fault_e fault_q;
  assign lk_ready  = !res_valid || res_ready;
  assign res_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      fault_q   <= FLT_NONE;
    end else if (lk_valid && lk_ready) begin
      res_valid <= 1'b1;
      res_hit   <= m_hit;
      res_pfn   <= m_pfn;
      fault_q   <= m_fault;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R11: a stalled result holds still
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_pfn) && $stable(res_fault)));

  // R10: an accepted lookup yields a result on the next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  // R10: a miss carries frame 0 and no fault
  a_r10_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_pfn == '0 && fault_q == FLT_NONE));

  // R7: a fault is only reported for a matched entry
  a_r7_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fault_q != FLT_NONE) |-> res_hit);

endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [18:0] res_pfn;
  logic [1:0]  res_fault;

  always #2.5 clk = ~clk;

  ctx_tlb dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_user(lk_user), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_pfn(res_pfn), .res_fault(res_fault)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // flags: bit3 shared, bit2 present, bit1 kernel, bit0 writable
  task automatic put(input int idx, input logic [18:0] vpn, input logic [5:0] tag,
                     input logic [18:0] pfn, input logic [3:0] fl);
    wr(2'd0, 32'(idx));
    wr(2'd1, {vpn, 7'd0, tag});
    wr(2'd2, {pfn, 9'd0, fl});
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic u);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = w; lk_user = u;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic chk_res(input string req, input logic h, input logic [1:0] f, input logic [18:0] p);
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"},   32'(res_hit),   32'(h));
    chk({req, " fault"}, 32'(res_fault), 32'(f));
    chk({req, " pfn"},   32'(res_pfn),   32'(p));
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic        hit;
    logic [1:0]  flt;
    logic [18:0] pfn;
  } vec_t;

  // lookups under running context 5
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h0002_6000, 1'b0, 1'b0, 1'b1, 2'd0, 19'h00AAA}, // R4 own context
    '{32'h0002_7ABC, 1'b1, 1'b1, 1'b1, 2'd0, 19'h00AAA}, // R4 offset ignored
    '{32'h0004_6000, 1'b0, 1'b0, 1'b0, 2'd0, 19'h00000}, // R4 other context
    '{32'h0020_A000, 1'b0, 1'b0, 1'b1, 2'd0, 19'h00CCC}, // R5 shared
    '{32'h0002_C000, 1'b0, 1'b0, 1'b0, 2'd0, 19'h00000}, // R6 reserved tag
    '{32'h0002_E000, 1'b1, 1'b1, 1'b1, 2'd1, 19'h00EEE}, // R7 absent wins
    '{32'h0003_0000, 1'b0, 1'b1, 1'b1, 2'd2, 19'h00FFF}, // R8 user->kernel
    '{32'h0003_0000, 1'b1, 1'b0, 1'b1, 2'd0, 19'h00FFF}, // R8 kernel ok
    '{32'h0003_2000, 1'b1, 1'b0, 1'b1, 2'd3, 19'h01234}, // R9 read-only
    '{32'h0003_2000, 1'b0, 1'b1, 1'b1, 2'd0, 19'h01234}, // R9 read ok
    '{32'h0003_4000, 1'b0, 1'b0, 1'b1, 2'd0, 19'h00111}, // R12 lowest way
    '{32'h0002_8000, 1'b0, 1'b0, 1'b0, 2'd0, 19'h00000}, // R4 wrong set
    '{32'h0006_6000, 1'b0, 1'b0, 1'b0, 2'd0, 19'h00000}  // R10 plain miss
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd3, d); chk("R1 ctx", d, 32'd0);
    rd(2'd1, d); chk("R1 upper", d, 32'h0000_003F);
    rd(2'd2, d); chk("R1 lower", d, 32'd0);
    chk("R1 no result", 32'(res_valid), 32'd0);
    look(32'h0000_0000, 1'b0, 1'b0);
    chk_res("R1 lookup", 1'b0, 2'd0, 19'd0);

    // populate; set = vpn[3:0] = index[5:2]
    wr(2'd3, 32'd5);
    put(12, 19'h00013, 6'd5,  19'h00AAA, 4'b0101);
    put(13, 19'h00023, 6'd7,  19'h00BBB, 4'b0101);
    put(22, 19'h00105, 6'd9,  19'h00CCC, 4'b1101);
    put(24, 19'h00016, 6'd63, 19'h00DDD, 4'b1101);
    put(29, 19'h00017, 6'd5,  19'h00EEE, 4'b0010);
    put(32, 19'h00018, 6'd5,  19'h00FFF, 4'b0111);
    put(39, 19'h00019, 6'd5,  19'h01234, 4'b0100);
    put(41, 19'h0001A, 6'd5,  19'h00111, 4'b0101);
    put(43, 19'h0001A, 6'd5,  19'h00333, 4'b0101);
    put(8,  19'h00014, 6'd5,  19'h00444, 4'b0101);

    // R2 readback
    wr(2'd0, 32'd12);
    rd(2'd0, d); chk("R2 index", d, 32'd12);
    rd(2'd1, d); chk("R2 upper", d, 32'h0002_6005);
    rd(2'd2, d); chk("R2 lower", d, {19'h00AAA, 13'h0005});

    for (int i = 0; i < NV; i++) begin
      look(VEC[i].va, VEC[i].wr, VEC[i].usr);
      chk_res($sformatf("vec%0d", i), VEC[i].hit, VEC[i].flt, VEC[i].pfn);
    end

    // R3 reserved context write ignored
    wr(2'd3, 32'd63);
    rd(2'd3, d); chk("R3 rsvd ignored", d, 32'd5);
    look(32'h0002_6000, 1'b0, 1'b0);
    chk_res("R3 still ctx5", 1'b1, 2'd0, 19'h00AAA);

    // R3 context switch
    wr(2'd3, 32'd7);
    look(32'h0004_6000, 1'b0, 1'b0);
    chk_res("R3 ctx7 hit", 1'b1, 2'd0, 19'h00BBB);
    look(32'h0002_6000, 1'b0, 1'b0);
    chk_res("R3 ctx5 entry misses", 1'b0, 2'd0, 19'd0);
    look(32'h0020_A000, 1'b0, 1'b0);
    chk_res("R5 shared under ctx7", 1'b1, 2'd0, 19'h00CCC);

    // R6 invalidate by retagging
    wr(2'd0, 32'd13);
    wr(2'd1, {19'h00023, 7'd0, 6'd63});
    look(32'h0004_6000, 1'b0, 1'b0);
    chk_res("R6 retagged", 1'b0, 2'd0, 19'd0);

    // R10 timing: nothing valid before the edge, result right after it
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h0020_A000; lk_write = 1'b0; lk_user = 1'b0;
    #1 chk("R10 not before edge", 32'(res_valid), 32'd0);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    chk("R10 after edge", 32'(res_valid), 32'd1);
    chk("R10 pfn", 32'(res_pfn), 32'h00CCC);

    // R11 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    lk_valid = 1'b1; lk_vaddr = 32'h0020_A000;
    @(negedge clk);
    lk_vaddr = 32'h0002_6000;   // ctx7 miss, must wait
    chk("R11 ready low", 32'(lk_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R11 held pfn", 32'(res_pfn), 32'h00CCC);
    chk("R11 held valid", 32'(res_valid), 32'd1);
    res_ready = 1'b1;
    #1 chk("R11 ready back", 32'(lk_ready), 32'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R11 next result", 32'(res_hit), 32'd0);
    chk("R11 next pfn", 32'(res_pfn), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule